// File: doc/BRIEF.md
# Bit-Sliced Add/Subtract Logic Unit

This block is a purely combinational arithmetic and logic unit whose word width is a parameter (32 bits by default). The word is cut into identical one-bit slices. Each slice produces the AND and the OR of its two operand bits, plus a full-adder sum and carry. A four-way selector inside the slice then chooses which of these becomes the slice's result bit. The carries run in a ripple chain from bit 0 to the top bit.

A single mode line switches the whole word between addition and subtraction. In subtract mode every bit of B is inverted through an XOR and a one is fed into the bottom carry, so the adder forms A + ~B + 1. The carry leaving the top slice is XORed with the effective mode, so that in subtract mode it reads as a borrow.

A fourth operation code returns an unsigned comparison taken from that borrow. For this operation the unit forces subtraction, whatever the mode line says. A separate flag reports unsigned less-than whenever the datapath is subtracting.

Top module: `alu_bitslice`

## Requirements
- R1: With `op_i` = 2'b00 the result is the bitwise AND of A and B.
- R2: With `op_i` = 2'b01 the result is the bitwise OR of A and B.
- R3: With `op_i` = 2'b10 and `sub_i` = 0 the result is (A + B) mod 2^W, and `carry_o` is the carry out of the top bit.
- R4: With `op_i` = 2'b10 and `sub_i` = 1 the result is (A - B) mod 2^W, and `carry_o` is 1 exactly when A < B as unsigned numbers.
- R5: With `op_i` = 2'b11 the result has bit 0 set exactly when A < B unsigned, and all higher bits zero, for either value of `sub_i`.
- R6: `lt_o` is 1 exactly when the effective operation is a subtraction (`sub_i` = 1 or `op_i` = 2'b11) and A < B unsigned. It is 0 whenever the unit adds.
- R7: With `op_i` = 2'b00 or 2'b01, `carry_o` still follows the mode line. With `sub_i` = 0 it is the carry of A + B; with `sub_i` = 1 it is the borrow of A - B.
- R8: With `op_i` = 2'b11, `carry_o` is the borrow of A - B whatever the value of `sub_i`.
- R9: The outputs depend only on the present inputs. They are valid after the input change, with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | Operand A |
| b_i | input | W | Operand B |
| sub_i | input | 1 | Mode line: 0 adds, 1 subtracts |
| op_i | input | 2 | Operation code: 00 AND, 01 OR, 10 arithmetic, 11 compare |
| result_o | output | W | Selected result word |
| carry_o | output | 1 | Word carry, corrected to a borrow when subtracting |
| lt_o | output | 1 | Unsigned A < B, valid while subtracting |

## Verification
The bench builds one copy at W = 4 and one at the default W = 32. At four bits, every operand pair, both modes and all four codes make 2048 cases. That sweep reaches every carry pattern along the chain, including a carry running from bit 0 through the top slice. The 32-bit copy is driven with the edge values: zero, all-ones, equal operands, operands one apart, and the sign boundary. It also runs a stream of generated operands. These cases check that the ripple chain and the borrow correction hold across the full default width.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        OP_AND = 2'b00,
        OP_OR  = 2'b01,
        OP_SUM = 2'b10,
        OP_CMP = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic and_b;
        logic or_b;
        logic sum_b;
        logic cry_b;
    } slice_res_t;

endpackage

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  logic    a_i,
    input  logic    b_i,
    input  logic    inv_i,
    input  logic    cin_i,
    input  alu_op_e op_i,
    output logic    res_o,
    output logic    cout_o
);

    slice_res_t bits_d;
    logic       b_eff;
    logic       prop;

    always_comb begin
        b_eff        = b_i ^ inv_i;
        prop         = a_i ^ b_eff;
        bits_d.and_b = a_i & b_i;
        bits_d.or_b  = a_i | b_i;
        bits_d.sum_b = prop ^ cin_i;
        bits_d.cry_b = (a_i & b_eff) | (prop & cin_i);
    end

    always_comb begin
        unique case (op_i)
            OP_AND:  res_o = bits_d.and_b;
            OP_OR:   res_o = bits_d.or_b;
            OP_SUM:  res_o = bits_d.sum_b;
            default: res_o = bits_d.cry_b;
        endcase
        cout_o = bits_d.cry_b;
    end

endmodule

// File: rtl/alu_ripple.sv
module alu_ripple
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         inv_i,
    input  alu_op_e      op_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);

    localparam int NCARRY = W + 1;

    logic [NCARRY-1:0] chain;

    assign chain[0] = inv_i;

    for (genvar gi = 0; gi < W; gi++) begin : g_slice
        alu_slice slice_i (
            .a_i    (a_i[gi]),
            .b_i    (b_i[gi]),
            .inv_i  (inv_i),
            .cin_i  (chain[gi]),
            .op_i   (op_i),
            .res_o  (res_o[gi]),
            .cout_o (chain[gi+1])
        );
    end

    assign cout_o = chain[NCARRY-1];

endmodule

// File: rtl/alu_bitslice.sv
module alu_bitslice
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic [1:0]   op_i,
    output logic [W-1:0] result_o,
    output logic         carry_o,
    output logic         lt_o
);

    alu_op_e      op_d;
    logic         sub_eff_d;
    logic [W-1:0] chain_res;
    logic         chain_cout;
    logic         fixed_cry_d;

    always_comb begin
        op_d      = alu_op_e'(op_i);
        sub_eff_d = sub_i | (op_d == OP_CMP);
    end

    alu_ripple #(.W(W)) ripple_i (
        .a_i    (a_i),
        .b_i    (b_i),
        .inv_i  (sub_eff_d),
        .op_i   (op_d),
        .res_o  (chain_res),
        .cout_o (chain_cout)
    );

    always_comb begin
        fixed_cry_d = chain_cout ^ sub_eff_d;
        if (op_d == OP_CMP) begin
            result_o    = '0;
            result_o[0] = fixed_cry_d;
        end else begin
            result_o = chain_res;
        end
        carry_o = fixed_cry_d;
        lt_o    = sub_eff_d & fixed_cry_d;
    end

endmodule

// File: rtl/alu_bitslice_chk.sv
module alu_bitslice_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic         sub_i,
    input logic [1:0]   op_i,
    input logic [W-1:0] result_o,
    input logic         carry_o,
    input logic         lt_o
);

    logic [W:0] ref_add;
    logic       known;

    always_comb begin
        ref_add = {1'b0, a_i} + {1'b0, b_i};
        known   = !$isunknown({a_i, b_i, sub_i, op_i});
        if (known) begin
            // R1
            and_op_chk: assert (op_i != 2'b00 || result_o == (a_i & b_i));
            // R2
            or_op_chk: assert (op_i != 2'b01 || result_o == (a_i | b_i));
            // R3
            add_res_chk: assert (op_i != 2'b10 || sub_i ||
                                 ({carry_o, result_o} == ref_add));
            // R4
            sub_res_chk: assert (op_i != 2'b10 || !sub_i ||
                                 (result_o == a_i - b_i && carry_o == (a_i < b_i)));
            // R5
            cmp_word_chk: assert (op_i != 2'b11 ||
                                  result_o == {{(W-1){1'b0}}, (a_i < b_i)});
            // R6
            lt_flag_chk: assert (lt_o == ((sub_i || op_i == 2'b11) && (a_i < b_i)));
            // R8
            cmp_carry_chk: assert (op_i != 2'b11 || carry_o == (a_i < b_i));
        end
    end

endmodule

bind alu_bitslice alu_bitslice_chk #(.W(W)) chk_i (
    .a_i      (a_i),
    .b_i      (b_i),
    .sub_i    (sub_i),
    .op_i     (op_i),
    .result_o (result_o),
    .carry_o  (carry_o),
    .lt_o     (lt_o)
);

// File: tb/alu_bitslice_tb_top.sv
module alu_bitslice_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int tests  = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [3:0]  a4, b4, r4;
    logic        s4, c4, l4;
    logic [1:0]  o4;
    logic [31:0] a32, b32, r32;
    logic        s32, c32, l32;
    logic [1:0]  o32;

    alu_bitslice #(.W(4)) dut_i (
        .a_i(a4), .b_i(b4), .sub_i(s4), .op_i(o4),
        .result_o(r4), .carry_o(c4), .lt_o(l4)
    );

    alu_bitslice #(.W(32)) dut32_i (
        .a_i(a32), .b_i(b32), .sub_i(s32), .op_i(o32),
        .result_o(r32), .carry_o(c32), .lt_o(l32)
    );

    task automatic check(string req, longint unsigned act, longint unsigned exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string res_req(int op, int s);
        if (op == 0) return "R1";
        if (op == 1) return "R2";
        if (op == 2) return s ? "R4" : "R3";
        return "R5";
    endfunction

    function automatic string cry_req(int op);
        if (op < 2) return "R7";
        if (op == 3) return "R8";
        return "R3/R4 carry";
    endfunction

    task automatic run_case(int w, longint unsigned a, longint unsigned b, int s, int op);
        longint unsigned mask, er, ec, el;
        bit lt, se;
        mask = (w == 64) ? '1 : ((64'd1 << w) - 1);
        lt = a < b;
        se = (s != 0) || (op == 3);
        case (op)
            0: er = a & b;
            1: er = a | b;
            2: er = s ? ((a - b) & mask) : ((a + b) & mask);
            default: er = lt;
        endcase
        ec = se ? lt : (((a + b) >> w) & 1);
        el = se & lt;
        if (w == 4) begin
            a4 = a[3:0]; b4 = b[3:0]; s4 = s[0]; o4 = op[1:0];
            #1;
            check(res_req(op, s), r4, er);
            check(cry_req(op), c4, ec);
            check("R6", l4, el);
        end else begin
            a32 = a[31:0]; b32 = b[31:0]; s32 = s[0]; o32 = op[1:0];
            #1;
            check(res_req(op, s), r32, er);
            check(cry_req(op), c32, ec);
            check("R6", l32, el);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        longint unsigned seed;
        longint unsigned corners [10];
        a4 = '0; b4 = '0; s4 = 1'b0; o4 = 2'b00;
        a32 = '0; b32 = '0; s32 = 1'b0; o32 = 2'b00;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 idle inputs give a zero result with no clock involved
        check("R9", r4, 0);
        check("R9", c4, 0);
        check("R9", l32, 0);
        // Exhaustive 4-bit sweep
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                for (int s = 0; s < 2; s++)
                    for (int op = 0; op < 4; op++)
                        run_case(4, longint'(a), longint'(b), s, op);
        // 32-bit corner operands
        corners = '{64'h0, 64'hFFFFFFFF, 64'h1, 64'hFFFFFFFE, 64'h80000000,
                    64'h7FFFFFFF, 64'h12345678, 64'h12345679, 64'h12345677, 64'hAAAAAAAA};
        for (int i = 0; i < 10; i++)
            for (int j = 0; j < 10; j++)
                for (int s = 0; s < 2; s++)
                    for (int op = 0; op < 4; op++)
                        run_case(32, corners[i], corners[j], s, op);
        // 32-bit generated operands
        seed = 64'h1F2E3D4C;
        for (int k = 0; k < 300; k++) begin
            longint unsigned ra, rb;
            seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
            ra = seed >> 32;
            seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
            rb = (k % 5 == 0) ? ra : (seed >> 32);
            for (int op = 0; op < 4; op++)
                run_case(32, ra, rb, k % 2, op);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule